// File: doc/BRIEF.md
# Shared-Bus Burst Write Sequencer

This block runs one synchronous burst write over an external bus whose address and data share the same lines. When idle it takes a request made of a start address, a word count and a set of programmed edge times. It then counts functional-clock cycles from the start of the access and drives the active-low chip-select, address-valid and write-enable strobes. It also drives a direction flag. On the shared bus it places first the address and then each write word in turn.

Every strobe edge is a programmed cycle number. Edges at or before the write access time take effect unchanged. When the access time is reached, the strobes stop moving while the remaining burst words step across the bus, each held for the page interval. Edges programmed after the access time are pushed later by that frozen window, and the whole access grows by the same amount. Write words are fetched by index: the block presents a word index and reads the word on a data input in the same cycle. When no access is running, the bus keeps the last value it drove.

Top module: `wbt_burst_writer`

## Requirements
- R1: Out of reset and whenever idle, `cs_n`, `adv_n` and `we_n` are 1, `dir_out` is 0 and `done` is 0. The shared bus reads 0 until the first access.
- R2: Cycle 0 is the first cycle after the clock edge that accepts a request. The access lasts T = C + P*(L-1) cycles, where C is `cfg_cycle` (0 counts as 1), P is the page interval and L is the word count. `dir_out` is 1 in exactly those cycles, and `done` is 1 for the single cycle that follows.
- R3: Define E(t) = t when t <= `cfg_access`, and E(t) = t + P*(L-1) otherwise. Each strobe is 0 in cycle c exactly when E(on) <= c < E(off), using that strobe's own on and off times.
- R4: In cycles `cfg_access`+1 through `cfg_access`+P*(L-1), the three strobes keep constant levels.
- R5: The bus carries the request address in cycles c < `cfg_data_on`. From `cfg_data_on` through `cfg_access`, it carries word 0.
- R6: Word k, for 1 <= k <= L-1, is on the bus in cycles `cfg_access`+1+(k-1)*P through `cfg_access`+k*P. The last word stays on the bus until the access ends. The word index `beat_idx` selects `beat_data`.
- R7: A word count of 1 gives a single access with no frozen window, and word 0 is held until the end. A `req_len` of 0 is treated as 1.
- R8: After an access, and until the next one starts, the bus keeps the last word driven.
- R9: A request raised while an access is running is ignored. The running access continues with unchanged timing and no extra `done`.
- R10: A page interval of 0 is treated as 1.
- R11: All timing fields, the address and the word count are captured when the request is accepted. Changes to them during the access have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start request, taken only when idle |
| req_addr | input | DW | Address placed on the bus first |
| req_len | input | LW | Number of burst words (0 means 1) |
| cfg_cs_on | input | 4 | Chip-select fall cycle |
| cfg_cs_off | input | 5 | Chip-select rise cycle |
| cfg_adv_on | input | 4 | Address-valid fall cycle |
| cfg_adv_off | input | 5 | Address-valid rise cycle |
| cfg_we_on | input | 4 | Write-enable fall cycle |
| cfg_we_off | input | 5 | Write-enable rise cycle |
| cfg_data_on | input | 4 | Cycle where word 0 replaces the address |
| cfg_access | input | 5 | Write access time; strobes freeze after it |
| cfg_page | input | 4 | Cycles each later burst word is held |
| cfg_cycle | input | 5 | Write cycle time before burst stretch |
| beat_data | input | DW | Write word selected by beat_idx |
| beat_idx | output | LW | Index of the word being driven |
| cs_n | output | 1 | Chip-select, active low |
| adv_n | output | 1 | Address-valid, active low |
| we_n | output | 1 | Write-enable, active low |
| dir_out | output | 1 | 1 while the bus is driven outward |
| ad_out | output | DW | Shared address/data bus |
| done | output | 1 | One-cycle pulse after the access ends |

## Verification
Several bursts are run: four words with a two-cycle page interval, a single word, a zero word count, a zero page interval that must act as one, and a fifteen-word burst. Together they show whether edges after the access time are remapped, whether the frozen window scales with both the interval and the count, and whether the degenerate encodings are clamped. One burst programs write-enable low during the address phase, and its word 0 must still appear at the data-on time. This separates a data start tied to the data-on field from one tied to the write-enable edge. In the same burst a second request and changed settings arrive mid-access; unchanged timing confirms capture at acceptance. The idle cycles after each burst show whether the bus holds the last word.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

    typedef struct packed {
        logic [3:0] cs_on;
        logic [4:0] cs_off;
        logic [3:0] adv_on;
        logic [4:0] adv_off;
        logic [3:0] we_on;
        logic [4:0] we_off;
        logic [3:0] data_on;
        logic [4:0] access;
        logic [3:0] page;
        logic [4:0] cycle;
    } wbt_timing_t;

    localparam int NUM_STROBES = 3;

endpackage

// File: rtl/wbt_timeline.sv
module wbt_timeline
    import wbt_pkg::*;
#(
    parameter int DW = 16,
    parameter int LW = 4,
    localparam int CW = LW + 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [DW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  wbt_timing_t   cfg_in,
    output logic          start,
    output logic          busy,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] extra,
    output logic [3:0]    page_eff,
    output logic [LW-1:0] len_eff,
    output logic [DW-1:0] addr,
    output wbt_timing_t   cfg,
    output logic          done
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [CW-1:0] last;
        logic [CW-1:0] extra;
        logic [3:0]    pbe;
        logic [LW-1:0] len;
        logic [DW-1:0] addr;
        wbt_timing_t   cfg;
        logic          done;
    } tl_state_t;

    tl_state_t s_d, s_q;
    logic [LW-1:0] len_new;
    logic [3:0]    pbe_new;
    logic [4:0]    cyc_new;
    logic [CW-1:0] extra_new;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        start     = req_valid && !s_q.busy;
        len_new   = (req_len == '0) ? LW'(1) : req_len;
        pbe_new   = (cfg_in.page == 4'd0) ? 4'd1 : cfg_in.page;
        cyc_new   = (cfg_in.cycle == 5'd0) ? 5'd1 : cfg_in.cycle;
        extra_new = CW'(pbe_new) * CW'(len_new - LW'(1));
        if (start) begin
            s_d.busy  = 1'b1;
            s_d.cnt   = '0;
            s_d.extra = extra_new;
            s_d.last  = CW'(cyc_new) + extra_new - CW'(1);
            s_d.pbe   = pbe_new;
            s_d.len   = len_new;
            s_d.addr  = req_addr;
            s_d.cfg   = cfg_in;
        end else if (s_q.busy) begin
            if (s_q.cnt == s_q.last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign cnt      = s_q.cnt;
    assign extra    = s_q.extra;
    assign page_eff = s_q.pbe;
    assign len_eff  = s_q.len;
    assign addr     = s_q.addr;
    assign cfg      = s_q.cfg;
    assign done     = s_q.done;

    // a request during an access neither restarts nor alters it
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && req_valid && s_q.cnt != s_q.last) |=>
        (s_q.busy && s_q.cnt == $past(s_q.cnt) + CW'(1) && $stable(s_q.cfg) && $stable(s_q.len)));

    assert_done_after_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (!s_q.busy && $past(s_q.busy)));

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> s_q.cnt <= s_q.last);

endmodule

// File: rtl/wbt_strobes.sv
module wbt_strobes #(
    parameter int NS = 3,
    parameter int CW = 10
) (
    input  logic [CW-1:0]        cnt,
    input  logic [4:0]           access,
    input  logic [CW-1:0]        extra,
    input  logic [NS-1:0][4:0]   on_t,
    input  logic [NS-1:0][4:0]   off_t,
    output logic [NS-1:0]        act
);

    for (genvar g = 0; g < NS; g++) begin : g_strobe
        logic [CW-1:0] e_on, e_off;
        always_comb begin
            e_on  = (on_t[g]  > access) ? CW'(on_t[g])  + extra : CW'(on_t[g]);
            e_off = (off_t[g] > access) ? CW'(off_t[g]) + extra : CW'(off_t[g]);
            act[g] = (cnt >= e_on) && (cnt < e_off);
        end
    end

endmodule

// File: rtl/wbt_beats.sv
module wbt_beats #(
    parameter int LW = 4,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          busy,
    input  logic [CW-1:0] cnt,
    input  logic [4:0]    access,
    input  logic [3:0]    page_eff,
    input  logic [LW-1:0] len_eff,
    output logic [LW-1:0] beat
);

    typedef struct packed {
        logic [LW-1:0] beat;
        logic [3:0]    sub;
    } bt_state_t;

    bt_state_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (start) begin
            b_d = '0;
        end else if (busy) begin
            if (cnt == CW'(access) && len_eff > LW'(1)) begin
                b_d.beat = LW'(1);
                b_d.sub  = 4'd0;
            end else if (b_q.beat != '0 && b_q.beat < len_eff - LW'(1)) begin
                if (b_q.sub == page_eff - 4'd1) begin
                    b_d.beat = b_q.beat + LW'(1);
                    b_d.sub  = 4'd0;
                end else begin
                    b_d.sub = b_q.sub + 4'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign beat = b_q.beat;

    assert_beat_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (b_q.beat < len_eff));

    assert_beat_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && b_q.beat != $past(b_q.beat)) |-> (b_q.beat == $past(b_q.beat) + LW'(1)));

endmodule

// File: rtl/wbt_burst_writer.sv
module wbt_burst_writer
    import wbt_pkg::*;
#(
    parameter int DW = 16,
    parameter int LW = 4,
    localparam int CW = LW + 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [DW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic [3:0]    cfg_cs_on,
    input  logic [4:0]    cfg_cs_off,
    input  logic [3:0]    cfg_adv_on,
    input  logic [4:0]    cfg_adv_off,
    input  logic [3:0]    cfg_we_on,
    input  logic [4:0]    cfg_we_off,
    input  logic [3:0]    cfg_data_on,
    input  logic [4:0]    cfg_access,
    input  logic [3:0]    cfg_page,
    input  logic [4:0]    cfg_cycle,
    input  logic [DW-1:0] beat_data,
    output logic [LW-1:0] beat_idx,
    output logic          cs_n,
    output logic          adv_n,
    output logic          we_n,
    output logic          dir_out,
    output logic [DW-1:0] ad_out,
    output logic          done
);

    wbt_timing_t cfg_in, cfg;
    logic          start, busy;
    logic [CW-1:0] cnt, extra;
    logic [3:0]    page_eff;
    logic [LW-1:0] len_eff;
    logic [DW-1:0] addr;
    logic [NUM_STROBES-1:0]      act;
    logic [NUM_STROBES-1:0][4:0] on_t, off_t;
    logic [DW-1:0] drive;

    typedef struct packed {
        logic [DW-1:0] keep;
    } bus_state_t;
    bus_state_t k_d, k_q;

    always_comb begin
        cfg_in.cs_on   = cfg_cs_on;
        cfg_in.cs_off  = cfg_cs_off;
        cfg_in.adv_on  = cfg_adv_on;
        cfg_in.adv_off = cfg_adv_off;
        cfg_in.we_on   = cfg_we_on;
        cfg_in.we_off  = cfg_we_off;
        cfg_in.data_on = cfg_data_on;
        cfg_in.access  = cfg_access;
        cfg_in.page    = cfg_page;
        cfg_in.cycle   = cfg_cycle;
    end

    wbt_timeline #(.DW(DW), .LW(LW)) u_timeline (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .cfg_in(cfg_in), .start(start), .busy(busy),
        .cnt(cnt), .extra(extra), .page_eff(page_eff), .len_eff(len_eff),
        .addr(addr), .cfg(cfg), .done(done)
    );

    assign on_t  = {{1'b0, cfg.we_on}, {1'b0, cfg.adv_on}, {1'b0, cfg.cs_on}};
    assign off_t = {cfg.we_off, cfg.adv_off, cfg.cs_off};

    wbt_strobes #(.NS(NUM_STROBES), .CW(CW)) u_strobes (
        .cnt(cnt), .access(cfg.access), .extra(extra),
        .on_t(on_t), .off_t(off_t), .act(act)
    );

    wbt_beats #(.LW(LW), .CW(CW)) u_beats (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .cnt(cnt),
        .access(cfg.access), .page_eff(page_eff), .len_eff(len_eff), .beat(beat_idx)
    );

    always_comb begin
        drive  = (cnt < CW'(cfg.data_on)) ? addr : beat_data;
        k_d    = k_q;
        if (busy) k_d.keep = drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign cs_n    = ~(busy & act[0]);
    assign adv_n   = ~(busy & act[1]);
    assign we_n    = ~(busy & act[2]);
    assign dir_out = busy;
    assign ad_out  = busy ? drive : k_q.keep;

    assert_idle_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_out |-> (cs_n && adv_n && we_n));

    assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dir_out);

    assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt > CW'(cfg.access) + CW'(1) && cnt <= CW'(cfg.access) + extra)
        |-> $stable({cs_n, adv_n, we_n}));

    assert_bus_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(ad_out));

endmodule

// File: tb/tb_wbt_burst_writer.sv
`timescale 1ns/1ps
module tb_wbt_burst_writer;

    localparam int DW = 16;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [DW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [3:0] cfg_cs_on = '0, cfg_adv_on = '0, cfg_we_on = '0, cfg_data_on = '0, cfg_page = '0;
    logic [4:0] cfg_cs_off = '0, cfg_adv_off = '0, cfg_we_off = '0, cfg_access = '0, cfg_cycle = '0;
    logic [DW-1:0] beat_data;
    logic [LW-1:0] beat_idx;
    logic cs_n, adv_n, we_n, dir_out, done;
    logic [DW-1:0] ad_out;
    logic [DW-1:0] word_mem [16];

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    assign beat_data = word_mem[beat_idx];

    wbt_burst_writer #(.DW(DW), .LW(LW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .cfg_cs_on(cfg_cs_on), .cfg_cs_off(cfg_cs_off),
        .cfg_adv_on(cfg_adv_on), .cfg_adv_off(cfg_adv_off), .cfg_we_on(cfg_we_on),
        .cfg_we_off(cfg_we_off), .cfg_data_on(cfg_data_on), .cfg_access(cfg_access),
        .cfg_page(cfg_page), .cfg_cycle(cfg_cycle), .beat_data(beat_data),
        .beat_idx(beat_idx), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
        .dir_out(dir_out), .ad_out(ad_out), .done(done)
    );

    typedef struct {
        logic [2:0]    strb;   // {we_n, adv_n, cs_n}
        logic          dir;
        logic          dn;
        logic [DW-1:0] ad;
        string         stag;
        string         btag;
        string         scen;
    } exp_t;

    exp_t q[$];

    function automatic void check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    function automatic int remap(input int t, input int acc, input int ext);
        return (t > acc) ? t + ext : t;
    endfunction

    // monitor: compares one expected item per cycle at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.scen, " ", e.stag, " strobes"}, DW'({we_n, adv_n, cs_n}), DW'(e.strb));
                check({e.scen, " R2 dir"}, DW'(dir_out), DW'(e.dir));
                check({e.scen, " R2 done"}, DW'(done), DW'(e.dn));
                check({e.scen, " ", e.btag, " bus"}, ad_out, e.ad);
            end
        end
    end

    task automatic run_burst(input string scen, input logic [DW-1:0] addr, input int len,
                             input int pg, input int cson, input int csoff, input int advon,
                             input int advoff, input int weon, input int weoff, input int don,
                             input int acc, input int cyc, input bit disturb);
        int le, pe, ext, tot, k;
        exp_t e;
        wait (q.size() == 0);
        @(negedge clk);
        for (int i = 0; i < 16; i++) word_mem[i] = addr ^ DW'(16'h1357 * (i + 1));
        req_addr = addr; req_len = LW'(len); cfg_page = 4'(pg);
        cfg_cs_on = 4'(cson); cfg_cs_off = 5'(csoff);
        cfg_adv_on = 4'(advon); cfg_adv_off = 5'(advoff);
        cfg_we_on = 4'(weon); cfg_we_off = 5'(weoff);
        cfg_data_on = 4'(don); cfg_access = 5'(acc); cfg_cycle = 5'(cyc);
        req_valid = 1'b1;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        le  = (len == 0) ? 1 : len;           // R7
        pe  = (pg == 0) ? 1 : pg;             // R10
        ext = pe * (le - 1);
        tot = ((cyc == 0) ? 1 : cyc) + ext;
        for (int c = 0; c < tot; c++) begin
            e.strb[0] = !(c >= remap(cson, acc, ext) && c < remap(csoff, acc, ext));
            e.strb[1] = !(c >= remap(advon, acc, ext) && c < remap(advoff, acc, ext));
            e.strb[2] = !(c >= remap(weon, acc, ext) && c < remap(weoff, acc, ext));
            e.dir = 1'b1;
            e.dn  = 1'b0;
            e.stag = (c > acc && c <= acc + ext) ? "R4" : "R3";
            e.scen = scen;
            if (c < don) begin
                e.ad = addr; e.btag = "R5";
            end else begin
                if (c <= acc) k = 0;
                else begin
                    k = (c - acc - 1) / pe + 1;
                    if (k > le - 1) k = le - 1;
                end
                e.ad = word_mem[k];
                e.btag = (k == 0) ? "R5" : "R6";
            end
            q.push_back(e);
        end
        for (int j = 0; j < 3; j++) begin
            e.strb = 3'b111; e.dir = 1'b0; e.dn = (j == 0);
            e.ad = word_mem[le - 1]; e.stag = "R1"; e.btag = "R8"; e.scen = scen;
            q.push_back(e);
        end
        if (disturb) begin
            // R9 and R11: new request and new settings in the middle of the access
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_len = 4'd7; cfg_cs_on = 4'd0; cfg_access = 5'd1;
            cfg_page = 4'd5; cfg_cycle = 5'd2; cfg_we_off = 5'd3; req_addr = 16'hFFFF;
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic run_all();
        for (int i = 0; i < 16; i++) word_mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset strobes", DW'({we_n, adv_n, cs_n}), DW'(3'b111));
        check("R1 reset dir", DW'(dir_out), '0);
        check("R1 reset done", DW'(done), '0);
        check("R1 reset bus", ad_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle strobes", DW'({we_n, adv_n, cs_n}), DW'(3'b111));
        check("R1 idle bus", ad_out, '0);
        run_burst("S1 R6 four words", 16'hA5C0, 4, 2, 1, 9, 0, 3, 2, 10, 3, 5, 8, 1'b0);
        run_burst("S2 R7 single", 16'h1234, 1, 3, 0, 6, 1, 2, 1, 5, 2, 4, 7, 1'b0);
        run_burst("S3 R10 page zero", 16'h0F0F, 3, 0, 2, 8, 0, 2, 3, 9, 4, 6, 9, 1'b0);
        run_burst("S4 R9 R11 we early", 16'h8421, 5, 3, 1, 12, 0, 2, 0, 11, 2, 4, 13, 1'b1);
        run_burst("S5 R7 len zero", 16'h5A5A, 0, 1, 0, 4, 0, 1, 1, 3, 1, 2, 5, 1'b0);
        run_burst("S6 R6 long", 16'hC3C3, 15, 1, 0, 6, 0, 1, 1, 6, 1, 3, 5, 1'b0);
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                bad++;
                total++;
                $display("FAIL watchdog R2 actual=timeout expected=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule